// File: doc/BRIEF.md
# Operand and Prefetch Bus Cycle Sequencer

This block is the bus-cycle engine behind a processor's execution sequencer. It accepts two kinds of request over separate ready/valid handshakes: data operands (byte, word or long, read or write) and 16-bit instruction prefetches. It turns each accepted request into one or more bus cycles on an external memory port. That port is either 8 or 16 bits wide, and the width is sampled at the start of every bus cycle. An operand that is wider than the port is broken into consecutive cycles, most significant part first. The bytes read back are gathered into a single right-aligned result.

Operands always win over prefetches. Once a request is taken, its bus cycles run back to back, and no other request is accepted until the last one ends. A change-of-flow hint from the pipeline stops new prefetches from starting. A prefetch that is already running still finishes, and its result is marked stale.

Each bus cycle holds a request strobe until the port acknowledges it. The port may insert any number of wait states. One done pulse then delivers the result.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: If the block is idle and `op_req_valid` is high, the operand is accepted at that edge and `pf_req_ready` is low, whatever `pf_req_valid` is.
- R2: An operand is one handshake. `op_size` encodes 0 = byte (1 byte), 1 = word (2 bytes), 2 = long (4 bytes), and 3 is treated as long. A prefetch is always 2 bytes.
- R3: Each bus cycle moves 2 bytes when `port_narrow` is low at its start and at least 2 bytes remain; otherwise it moves 1 byte. A word on an 8-bit port therefore takes two cycles, a long on a 16-bit port takes two, and a long on an 8-bit port takes four.
- R4: The cycles of one request go most significant part first. The first cycle uses the request address, and each later cycle's address is the previous one plus the bytes that cycle moved. Word and long addresses are expected to be even.
- R5: While `cof_pending` is high, `pf_req_ready` is low and no prefetch is accepted.
- R6: A prefetch already in progress runs to completion and returns its data. `rsp_stale` is 1 if `cof_pending` was high at any clock edge from the edge after acceptance through the final acknowledge, and 0 otherwise.
- R7: Lane steering on `bus_wdata` / `bus_lane`:
  - A 2-byte cycle places the more significant byte on [15:8], with lane 2'b11.
  - An 8-bit-port cycle uses [7:0], with lane 2'b01.
  - A 1-byte cycle on a 16-bit port uses [15:8] (lane 2'b10) at an even address and [7:0] (lane 2'b01) at an odd one.
  - Unused lanes and all read cycles drive zero.
- R8: Read bytes are taken from the enabled lanes of `bus_rdata`, packed most significant first and right-aligned in `rsp_data`, with the upper bits zero. A write reports `rsp_data` = 0.
- R9: `rsp_valid` pulses for exactly one cycle, in the cycle after the edge where the final cycle is acknowledged. `rsp_is_pf` gives the source of that response.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_addr`, `bus_write`, `bus_wdata` and `bus_lane` hold their values. A cycle ends at the edge where `bus_ack` is high.
- R11: From acceptance until the final acknowledge, both ready outputs are low. Cycles of different requests never interleave.
- R12: During reset, `bus_req` and `rsp_valid` are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_req_valid | input | 1 | Operand request present |
| op_req_ready | output | 1 | Operand request accepted this cycle when valid |
| op_addr | input | AW | Operand byte address |
| op_size | input | 2 | Operand size code |
| op_write | input | 1 | 1 = write, 0 = read |
| op_wdata | input | 32 | Right-aligned write operand |
| pf_req_valid | input | 1 | Prefetch request present |
| pf_req_ready | output | 1 | Prefetch accepted this cycle when valid |
| pf_addr | input | AW | Prefetch address (even) |
| cof_pending | input | 1 | Change of flow imminent |
| rsp_valid | output | 1 | Done pulse |
| rsp_data | output | 32 | Packed read result |
| rsp_is_pf | output | 1 | Response belongs to a prefetch |
| rsp_stale | output | 1 | Prefetch overtaken by change of flow |
| bus_req | output | 1 | Bus cycle strobe |
| bus_addr | output | AW | Bus cycle address |
| bus_write | output | 1 | Bus cycle direction |
| bus_wdata | output | 16 | Steered write data |
| bus_lane | output | 2 | Byte lanes in use ([1] = 15:8, [0] = 7:0) |
| bus_ack | input | 1 | Cycle acknowledge |
| bus_rdata | input | 16 | Read data from the port |
| port_narrow | input | 1 | 1 = 8-bit port, 0 = 16-bit port |

## Verification
The properties assume three things about the surroundings:
- the port raises `bus_ack` only while `bus_req` is high;
- word, long and prefetch addresses are even;
- a requester keeps its valid and payload steady until the handshake completes.

The bench stays within these limits. Acknowledges are randomly delayed but issued only during a strobe. Addresses are masked even except for bytes, and each request is held until the model records its acceptance. `port_narrow` is held wide, then narrow, and then changed on arbitrary cycles so that mid-operand width changes occur. `cof_pending` toggles freely so that prefetches are blocked and prefetches in progress are marked stale.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int unsigned OPND_W = 32;
  localparam int unsigned PORT_W = 16;

  typedef enum logic [1:0] {
    OPSZ_BYTE = 2'd0,
    OPSZ_WORD = 2'd1,
    OPSZ_LONG = 2'd2,
    OPSZ_RSVD = 2'd3
  } opsize_e;

  function automatic logic [2:0] opsize_bytes(input logic [1:0] sz);
    case (opsize_e'(sz))
      OPSZ_BYTE: return 3'd1;
      OPSZ_WORD: return 3'd2;
      default:   return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/bcc_arbiter.sv
module bcc_arbiter (
  input  logic busy,
  input  logic op_valid,
  input  logic pf_valid,
  input  logic cof_pending,
  output logic op_ready,
  output logic pf_ready,
  output logic take_op,
  output logic take_pf
);
  always_comb begin
    op_ready = !busy;
    pf_ready = !busy && !op_valid && !cof_pending;
    take_op  = op_valid && op_ready;
    take_pf  = pf_valid && pf_ready;
  end
endmodule

// File: rtl/bcc_chunker.sv
module bcc_chunker import bcc_pkg::*; (
  input  logic [2:0]        rem,
  input  logic              narrow,
  input  logic              addr_lsb,
  input  logic [OPND_W-1:0] wsh,
  output logic              wide,
  output logic [1:0]        lane,
  output logic [PORT_W-1:0] wdata
);
  localparam int unsigned BYTE_W = PORT_W / 2;

  always_comb begin
    wide = !narrow && (rem >= 3'd2);
    if (wide)                    lane = 2'b11;
    else if (narrow || addr_lsb) lane = 2'b01;
    else                         lane = 2'b10;
    case (lane)
      2'b11:   wdata = wsh[OPND_W-1 -: PORT_W];
      2'b10:   wdata = {wsh[OPND_W-1 -: BYTE_W], {BYTE_W{1'b0}}};
      default: wdata = {{BYTE_W{1'b0}}, wsh[OPND_W-1 -: BYTE_W]};
    endcase
  end
endmodule

// File: rtl/bcc_packer.sv
module bcc_packer import bcc_pkg::*; #(
  parameter int unsigned W = OPND_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              capture,
  input  logic [1:0]        lane,
  input  logic [PORT_W-1:0] rdata,
  output logic [W-1:0]      acc_next
);
  localparam int unsigned BYTE_W = PORT_W / 2;

  logic [W-1:0] acc_q;

  always_comb begin
    case (lane)
      2'b11:   acc_next = {acc_q[W-PORT_W-1:0], rdata};
      2'b10:   acc_next = {acc_q[W-BYTE_W-1:0], rdata[PORT_W-1 -: BYTE_W]};
      default: acc_next = {acc_q[W-BYTE_W-1:0], rdata[BYTE_W-1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (capture) acc_q <= acc_next;
  end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl import bcc_pkg::*; #(
  parameter int unsigned AW = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_req_valid,
  output logic              op_req_ready,
  input  logic [AW-1:0]     op_addr,
  input  logic [1:0]        op_size,
  input  logic              op_write,
  input  logic [OPND_W-1:0] op_wdata,
  input  logic              pf_req_valid,
  output logic              pf_req_ready,
  input  logic [AW-1:0]     pf_addr,
  input  logic              cof_pending,
  output logic              rsp_valid,
  output logic [OPND_W-1:0] rsp_data,
  output logic              rsp_is_pf,
  output logic              rsp_stale,
  output logic              bus_req,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_write,
  output logic [PORT_W-1:0] bus_wdata,
  output logic [1:0]        bus_lane,
  input  logic              bus_ack,
  input  logic [PORT_W-1:0] bus_rdata,
  input  logic              port_narrow
);
  localparam logic [2:0] PF_BYTES = 3'd2;

  logic              busy_q, cur_pf_q, cur_wr_q, take2_q, stale_q;
  logic [2:0]        rem_q;
  logic [AW-1:0]     addr_q;
  logic [OPND_W-1:0] wsh_q;
  logic [1:0]        lane_q;
  logic [PORT_W-1:0] wdata_q;
  logic              rsp_valid_q, rsp_pf_q, rsp_stale_q;
  logic [OPND_W-1:0] rsp_data_q;

  logic              take_op, take_pf, start, beat_done, last, load_en;
  logic [2:0]        n_cur, rem_after, nxt_rem;
  logic [AW-1:0]     nxt_addr;
  logic [OPND_W-1:0] wsh_load, nxt_wsh, acc_next;
  logic              ck_wide;
  logic [1:0]        ck_lane;
  logic [PORT_W-1:0] ck_wdata;

  bcc_arbiter u_arb (
    .busy(busy_q), .op_valid(op_req_valid), .pf_valid(pf_req_valid),
    .cof_pending(cof_pending), .op_ready(op_req_ready), .pf_ready(pf_req_ready),
    .take_op(take_op), .take_pf(take_pf)
  );

  always_comb begin
    start     = take_op || take_pf;
    n_cur     = take2_q ? 3'd2 : 3'd1;
    rem_after = rem_q - n_cur;
    beat_done = busy_q && bus_ack;
    last      = beat_done && (rem_after == 3'd0);
    load_en   = start || (beat_done && !last);
    case (opsize_e'(op_size))
      OPSZ_BYTE: wsh_load = {op_wdata[7:0], 24'h0};
      OPSZ_WORD: wsh_load = {op_wdata[15:0], 16'h0};
      default:   wsh_load = op_wdata;
    endcase
    if (!(take_op && op_write)) wsh_load = '0;
    if (busy_q) begin
      nxt_rem  = rem_after;
      nxt_addr = addr_q + AW'(n_cur);
      nxt_wsh  = take2_q ? {wsh_q[OPND_W-17:0], 16'h0} : {wsh_q[OPND_W-9:0], 8'h0};
    end else begin
      nxt_rem  = take_op ? opsize_bytes(op_size) : PF_BYTES;
      nxt_addr = take_op ? op_addr : pf_addr;
      nxt_wsh  = wsh_load;
    end
  end

  bcc_chunker u_chunk (
    .rem(nxt_rem), .narrow(port_narrow), .addr_lsb(nxt_addr[0]), .wsh(nxt_wsh),
    .wide(ck_wide), .lane(ck_lane), .wdata(ck_wdata)
  );

  bcc_packer #(.W(OPND_W)) u_pack (
    .clk(clk), .rst(rst), .clear(start), .capture(beat_done),
    .lane(lane_q), .rdata(bus_rdata), .acc_next(acc_next)
  );

  // Per-cycle datapath registers, reloaded at each cycle start.
  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      addr_q  <= '0;
      wsh_q   <= '0;
      take2_q <= 1'b0;
      lane_q  <= 2'b00;
      wdata_q <= '0;
    end else if (load_en) begin
      rem_q   <= nxt_rem;
      addr_q  <= nxt_addr;
      wsh_q   <= nxt_wsh;
      take2_q <= ck_wide;
      lane_q  <= ck_lane;
      wdata_q <= ck_wdata;
    end
  end

  // Request-level control and the response register.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      cur_pf_q    <= 1'b0;
      cur_wr_q    <= 1'b0;
      stale_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_pf_q    <= 1'b0;
      rsp_stale_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q   <= 1'b1;
          cur_pf_q <= take_pf;
          cur_wr_q <= take_op && op_write;
          stale_q  <= 1'b0;
        end
      end else begin
        if (cur_pf_q && cof_pending) stale_q <= 1'b1;
        if (last) begin
          busy_q      <= 1'b0;
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= cur_wr_q ? '0 : acc_next;
          rsp_pf_q    <= cur_pf_q;
          rsp_stale_q <= stale_q || (cur_pf_q && cof_pending);
        end
      end
    end
  end

  assign bus_req   = busy_q;
  assign bus_addr  = addr_q;
  assign bus_write = cur_wr_q;
  assign bus_wdata = wdata_q;
  assign bus_lane  = lane_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_is_pf = rsp_pf_q;
  assign rsp_stale = rsp_stale_q;

  assert_op_first_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && op_req_valid) |=> (busy_q && !cur_pf_q));

  assert_no_pf_on_cof_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && cof_pending) |=> !(busy_q && cur_pf_q));

  assert_stale_mark_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cur_pf_q && cof_pending && !bus_ack) |=> stale_q);

  assert_lane_used_R7: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_lane != 2'b00));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_wait_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata)
                               && $stable(bus_lane) && $stable(bus_write)));

  assert_no_interleave_R11: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !bus_ack) |=> (busy_q && $stable(cur_pf_q) && !op_req_ready));
endmodule

// File: tb/test_bus_cycle_ctrl.sv
module test_bus_cycle_ctrl;
  localparam int AW = 24;
  localparam int NCYC = 8000;

  logic clk = 1'b0, rst = 1'b1;
  logic op_req_valid = 0, op_write = 0, pf_req_valid = 0, cof_pending = 0;
  logic [AW-1:0] op_addr = '0, pf_addr = '0;
  logic [1:0] op_size = 2'd0;
  logic [31:0] op_wdata = '0;
  logic bus_ack = 0, port_narrow = 0;
  logic [15:0] bus_rdata = '0;
  logic op_req_ready, pf_req_ready, rsp_valid, rsp_is_pf, rsp_stale;
  logic [31:0] rsp_data;
  logic bus_req, bus_write;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [1:0] bus_lane;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  bus_cycle_ctrl #(.AW(AW)) i_bus_cycle_ctrl (
    .clk(clk), .rst(rst),
    .op_req_valid(op_req_valid), .op_req_ready(op_req_ready), .op_addr(op_addr),
    .op_size(op_size), .op_write(op_write), .op_wdata(op_wdata),
    .pf_req_valid(pf_req_valid), .pf_req_ready(pf_req_ready), .pf_addr(pf_addr),
    .cof_pending(cof_pending),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_is_pf(rsp_is_pf), .rsp_stale(rsp_stale),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_lane(bus_lane), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .port_narrow(port_narrow)
  );

  // Behavioural reference model
  bit m_busy, m_pf, m_wr, m_stale, m_rv, m_rpf, m_rstale, m_took_op, m_took_pf;
  int m_rem, m_n, m_idx, m_lane, m_wd, m_addr;
  int m_wb[4];
  logic [31:0] m_acc, m_rd;
  int stat_stale = 0, stat_narrow_long = 0;

  function automatic void m_start_cycle();
    m_n = (!port_narrow && m_rem >= 2) ? 2 : 1;
    if (m_n == 2) begin
      m_lane = 3; m_wd = (m_wb[m_idx] << 8) | m_wb[m_idx+1];
    end else if (port_narrow || (m_addr % 2 == 1)) begin
      m_lane = 1; m_wd = m_wb[m_idx];
    end else begin
      m_lane = 2; m_wd = m_wb[m_idx] << 8;
    end
  endfunction

  always @(posedge clk) begin
    m_rv = 0; m_took_op = 0; m_took_pf = 0;
    if (rst) begin
      m_busy = 0;
    end else if (m_busy) begin
      if (m_pf && cof_pending) m_stale = 1;
      if (bus_ack) begin
        if (m_lane == 3)      m_acc = {m_acc[15:0], bus_rdata};
        else if (m_lane == 2) m_acc = {m_acc[23:0], bus_rdata[15:8]};
        else                  m_acc = {m_acc[23:0], bus_rdata[7:0]};
        m_rem -= m_n; m_idx += m_n; m_addr = (m_addr + m_n) % (1 << AW);
        if (m_rem == 0) begin
          m_busy = 0; m_rv = 1; m_rd = m_wr ? 32'h0 : m_acc;
          m_rpf = m_pf; m_rstale = m_stale;
          if (m_stale) stat_stale++;
        end else m_start_cycle();
      end
    end else if (op_req_valid) begin
      m_took_op = 1; m_busy = 1; m_pf = 0; m_wr = op_write; m_stale = 0; m_acc = 0;
      m_rem = (op_size == 0) ? 1 : (op_size == 1) ? 2 : 4;
      if (m_rem == 4 && port_narrow) stat_narrow_long++;
      m_addr = int'(op_addr); m_idx = 0;
      for (int i = 0; i < 4; i++)
        m_wb[i] = (op_write && i < m_rem) ? int'((op_wdata >> (8*(m_rem-1-i))) & 32'hff) : 0;
      m_start_cycle();
    end else if (pf_req_valid && !cof_pending) begin
      m_took_pf = 1; m_busy = 1; m_pf = 1; m_wr = 0; m_stale = 0; m_acc = 0;
      m_rem = 2; m_addr = int'(pf_addr); m_idx = 0;
      for (int i = 0; i < 4; i++) m_wb[i] = 0;
      m_start_cycle();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      // registered outputs
      chk(bus_req === m_busy, "R12 R11 bus_req", 32'(bus_req), 32'(m_busy));
      chk(rsp_valid === m_rv, "R12 R9 rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_busy) begin
        chk(bus_addr === AW'(m_addr), "R4 R10 bus_addr", 32'(bus_addr), 32'(m_addr));
        chk(bus_write === m_wr, "R2 bus_write", 32'(bus_write), 32'(m_wr));
        chk(bus_lane === 2'(m_lane), "R3 R7 bus_lane", 32'(bus_lane), 32'(m_lane));
        chk(bus_wdata === 16'(m_wd), "R7 bus_wdata", 32'(bus_wdata), 32'(m_wd));
      end
      if (m_rv) begin
        chk(rsp_data === m_rd, "R8 rsp_data", rsp_data, m_rd);
        chk(rsp_is_pf === m_rpf, "R9 rsp_is_pf", 32'(rsp_is_pf), 32'(m_rpf));
        chk(rsp_stale === m_rstale, "R6 rsp_stale", 32'(rsp_stale), 32'(m_rstale));
      end
      // drive new inputs
      if (cyc == 3) rst = 1'b0;
      if (m_took_op) op_req_valid = 0;
      if (m_took_pf) pf_req_valid = 0;
      if (!op_req_valid && ($urandom % 5 == 0)) begin
        op_req_valid = 1;
        op_size  = 2'($urandom % 3);
        op_write = 1'($urandom % 2);
        op_wdata = $urandom;
        op_addr  = AW'($urandom);
        if (op_size != 2'd0) op_addr[0] = 1'b0;
      end
      if (!pf_req_valid && ($urandom % 3 == 0)) begin
        pf_req_valid = 1;
        pf_addr = AW'($urandom) & ~AW'(1);
      end
      if ($urandom % 6 == 0) cof_pending = ~cof_pending;
      if (cyc < NCYC / 3)          port_narrow = 1'b0;
      else if (cyc < 2 * NCYC / 3) port_narrow = 1'b1;
      else                         port_narrow = 1'($urandom % 2);
      bus_ack   = bus_req && ($urandom % 3 != 0);
      bus_rdata = 16'($urandom);
      #1;
      chk(op_req_ready === !m_busy, "R11 R2 op_req_ready", 32'(op_req_ready), 32'(!m_busy));
      chk(pf_req_ready === (!m_busy && !op_req_valid && !cof_pending),
          "R1 R5 pf_req_ready", 32'(pf_req_ready),
          32'(!m_busy && !op_req_valid && !cof_pending));
    end
    chk(stat_stale > 0, "R6 stale prefetch seen", 32'(stat_stale), 32'(1));
    chk(stat_narrow_long > 0, "R3 long on 8-bit port seen", 32'(stat_narrow_long), 32'(1));
    finish_run();
  end
endmodule